// File: doc/BRIEF.md
# Stochastic Chebyshev Series Evaluator

This block evaluates a truncated Chebyshev series on bipolar stochastic bit streams. It runs the Clenshaw recurrence as a serial chain of ORDER+1 stages, one per term. Every stage is a constant-weight stochastic dot product. It combines three streams: its own coefficient stream, the XNOR of the x stream with the output of the stage just above it, and the output of the stage two above it. The lowest stage (index 0) drives the block output. The x stream must already be scaled by the bipolar range L, which cancels the 1/L factor that the XNOR product introduces.

Each clock the block takes one x bit and ORDER+1 coefficient bits, and it gives one output bit. All stages share one block period of M clocks. A stage adds up weighted input bits over a block. At the block boundary it turns the sum into a ones-count for its next M output bits, and a signed carry keeps whatever the clamp to [0, M] cut off. Changing the coefficient streams selects another function of the same order. A parameter mask removes the coefficient term of any stage whose coefficient is known to be zero, which lowers noise for odd and even functions.

Top module: `sc_cheb_eval`

## Requirements
- R1: Reset is synchronous and active-high. The first clock after reset is phase 0 of block 0, and block boundaries then fall every M clocks. Every stage leaves reset with a ones-count of M/2 and a carry of 0. So in block 0, `outBit` is 1 in phases 0 to M/2-1 and 0 in the other phases. `outValid` is 0 during reset.
- R2: At each block boundary, stage n forms S = M·(1−W)/2 + Σ (weight × input bit) over the M clocks of the block, where W is the sum of its three weights. It then forms E = S + carry.
- R3: The product input of stage n is the XNOR of `xBit` and the output bit of stage n+1 in the same clock.
- R4: Weights on (coefficient, product, stage n+2 output) are (1, 2, −1) for 0 < n < ORDER−1. Stage ORDER−1 uses (1, 2, 0) and stage ORDER uses (1, 0, 0). Stage 0 uses 1 on the product term; below ORDER−1 its n+2 weight is −1.
- R5: The new ones-count is E clamped to [0, M], and the new carry is E minus that count. A positive carry only exists with a count of M, and a negative carry only with a count of 0.
- R6: Within a block, a stage whose ones-count is c outputs 1 in phases 0 to c−1 and 0 in phases c to M−1.
- R7: `outValid` rises at phase 0 of block ORDER+1, which is (ORDER+1)·M clocks after reset, and stays high until the next reset.
- R8: When bit n of COEF_MASK is 0, the weight of `coefBits[n]` is 0, so that input has no effect on `outBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xBit | input | 1 | Bipolar x stream, prescaled by L |
| coefBits | input | ORDER+1 | Coefficient stream bit for each stage; bit n feeds stage n |
| outBit | output | 1 | Bipolar stream of the series value (stage 0 output) |
| outValid | output | 1 | High once every stage has finished at least one block |

## Verification
The hardest situation to reach is a stage whose estimate leaves [0, M], so that carry builds up and drains over several blocks through the whole chain. From the ports this happens only when several stages saturate together. The stimulus holds x at +1, −1 and 0 by driving constant or alternating streams, and drives every coefficient at the extremes of its range with a ones-first pattern inside each block. A block-level model of the recurrence then predicts every output bit. A second instance with one coefficient masked is run twice with that coefficient at opposite extremes, and its two output streams must match bit for bit.

// File: rtl/sce_pkg.sv
package sce_pkg;

  // Strobes sent from the block sequencer to the stage datapath.
  typedef struct packed {
    logic blockEnd;  // last clock of the current block
    logic zeroBit;   // bipolar zero stream: alternates 0,1 by phase
  } strobe_t;

  // Integer weights of one stage: coefficient, product, n+2 term.
  typedef struct packed {
    int coefW;
    int prodW;
    int skipW;
  } weightSet_t;

  // Weights of stage idx in a chain with top index order (R4, R8).
  function automatic weightSet_t stageWeights(input int idx, input int order,
                                              input bit coefOn);
    weightSet_t w;
    w.coefW = coefOn ? 1 : 0;
    if (idx == order)      w.prodW = 0;
    else if (idx == 0)     w.prodW = 1;
    else                   w.prodW = 2;
    w.skipW = (idx >= order - 1) ? 0 : -1;
    return w;
  endfunction

endpackage

// File: rtl/sce_ctrl.sv
module sce_ctrl
  import sce_pkg::*;
#(
  parameter int M     = 8,
  parameter int ORDER = 3,
  localparam int PH_W = (M > 1) ? $clog2(M) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output strobe_t         strobes,
  output logic [PH_W-1:0] phase,
  output logic            chainValid
);

  logic [ORDER:0] validReg;
  logic           lastPhase;

  assign lastPhase = (phase == PH_W'(M - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      validReg <= '0;
    end else begin
      phase <= lastPhase ? '0 : phase + 1'b1;
      if (lastPhase) validReg <= {1'b1, validReg[ORDER:1]};
    end
  end

  always_comb begin
    strobes.blockEnd = lastPhase;
    strobes.zeroBit  = phase[0];
  end

  assign chainValid = validReg[0];

  // R1: blocks are exactly M clocks long
  assert_block_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.blockEnd |=> (phase == '0));

  // R7: valid never drops without reset
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    chainValid |=> chainValid);

  // R7: valid rises only on a block boundary
  assert_valid_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(chainValid) |-> (phase == '0));

endmodule

// File: rtl/sce_stage.sv
module sce_stage #(
  parameter int M       = 8,
  parameter int CARRY_W = 16,
  parameter int COEF_W  = 1,
  parameter int PROD_W  = 2,
  parameter int SKIP_W  = -1,
  localparam int PH_W   = (M > 1) ? $clog2(M) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blockEnd,
  input  logic [PH_W-1:0] phase,
  input  logic            xBit,
  input  logic            coefBit,
  input  logic            nextBit,
  input  logic            skipBit,
  output logic            outBit
);

  localparam int CNT_W = $clog2(M + 1);
  localparam int SUM_W = CNT_W + 4;
  localparam int EST_W = ((CARRY_W > SUM_W) ? CARRY_W : SUM_W) + 2;
  localparam int BASE  = (M * (1 - (COEF_W + PROD_W + SKIP_W))) / 2;
  localparam logic signed [EST_W-1:0] C_MAX =
    {{(EST_W - CARRY_W + 1){1'b0}}, {(CARRY_W - 1){1'b1}}};
  localparam logic signed [EST_W-1:0] C_MIN = -C_MAX - 1;

  logic signed [SUM_W-1:0]   acc, inc, accNext;
  logic signed [CARRY_W-1:0] carry, carryNext;
  logic signed [EST_W-1:0]   est, resid;
  logic [CNT_W-1:0]          outCount, clampCnt;
  logic                      prodBit;

  // R3: bipolar product by XNOR
  assign prodBit = ~(xBit ^ nextBit);

  // R2, R4: weighted bit sum for this clock
  always_comb begin
    inc = '0;
    if (coefBit) inc = inc + SUM_W'(COEF_W);
    if (prodBit) inc = inc + SUM_W'(PROD_W);
    if (skipBit) inc = inc + SUM_W'(SKIP_W);
    accNext = acc + inc;
  end

  // R5: clamp to an expressible count, keep the remainder as carry
  always_comb begin
    est = EST_W'(accNext) + EST_W'(carry);
    if (est < 0)                 clampCnt = '0;
    else if (est > EST_W'(M))    clampCnt = CNT_W'(M);
    else                         clampCnt = est[CNT_W-1:0];
    resid = est - EST_W'($signed({1'b0, clampCnt}));
    if (resid > C_MAX)           carryNext = C_MAX[CARRY_W-1:0];
    else if (resid < C_MIN)      carryNext = C_MIN[CARRY_W-1:0];
    else                         carryNext = resid[CARRY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= SUM_W'(BASE);
      outCount <= CNT_W'(M / 2);
      carry    <= '0;
    end else if (blockEnd) begin
      acc      <= SUM_W'(BASE);
      outCount <= clampCnt;
      carry    <= carryNext;
    end else begin
      acc      <= accNext;
    end
  end

  // R6: ones first, then zeros
  assign outBit = (CNT_W'(phase) < outCount);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    outCount <= CNT_W'(M));

  assert_carry_high_R5: assert property (@(posedge clk) disable iff (rst)
    (carry > 0) |-> (outCount == CNT_W'(M)));

  assert_carry_low_R5: assert property (@(posedge clk) disable iff (rst)
    (carry < 0) |-> (outCount == '0));

  assert_ones_first_R6: assert property (@(posedge clk) disable iff (rst)
    (!outBit && !blockEnd) |=> !outBit);

endmodule

// File: rtl/sce_datapath.sv
module sce_datapath
  import sce_pkg::*;
#(
  parameter int             M         = 8,
  parameter int             ORDER     = 3,
  parameter int             CARRY_W   = 16,
  parameter logic [ORDER:0] COEF_MASK = '1,
  localparam int PH_W = (M > 1) ? $clog2(M) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         strobes,
  input  logic [PH_W-1:0] phase,
  input  logic            xBit,
  input  logic [ORDER:0]  coefBits,
  output logic            outBit
);

  logic stageOut [0:ORDER+2];

  // Terms above the top of the chain read the bipolar zero stream.
  assign stageOut[ORDER+1] = strobes.zeroBit;
  assign stageOut[ORDER+2] = strobes.zeroBit;

  for (genvar n = 0; n <= ORDER; n++) begin : g_stage
    localparam weightSet_t WS = stageWeights(n, ORDER, COEF_MASK[n]);
    sce_stage #(
      .M      (M),
      .CARRY_W(CARRY_W),
      .COEF_W (WS.coefW),
      .PROD_W (WS.prodW),
      .SKIP_W (WS.skipW)
    ) stage_i (
      .clk     (clk),
      .rst     (rst),
      .blockEnd(strobes.blockEnd),
      .phase   (phase),
      .xBit    (xBit),
      .coefBit (coefBits[n]),
      .nextBit (stageOut[n+1]),
      .skipBit (stageOut[n+2]),
      .outBit  (stageOut[n])
    );
  end

  assign outBit = stageOut[0];

endmodule

// File: rtl/sc_cheb_eval.sv
module sc_cheb_eval
  import sce_pkg::*;
#(
  parameter int             ORDER     = 3,
  parameter int             BLOCK_LEN = 8,
  parameter int             CARRY_W   = 16,
  parameter logic [ORDER:0] COEF_MASK = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xBit,
  input  logic [ORDER:0] coefBits,
  output logic           outBit,
  output logic           outValid
);

  localparam int PH_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;

  strobe_t         strobes;
  logic [PH_W-1:0] phase;

  sce_ctrl #(
    .M    (BLOCK_LEN),
    .ORDER(ORDER)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .phase     (phase),
    .chainValid(outValid)
  );

  sce_datapath #(
    .M        (BLOCK_LEN),
    .ORDER    (ORDER),
    .CARRY_W  (CARRY_W),
    .COEF_MASK(COEF_MASK)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .phase   (phase),
    .xBit    (xBit),
    .coefBits(coefBits),
    .outBit  (outBit)
  );

endmodule

// File: tb/sc_cheb_eval_tb_top.sv
`timescale 1ns/1ps
module sc_cheb_eval_tb_top;

  localparam int N  = 3;
  localparam int M  = 8;
  localparam int NB = 12;
  localparam logic [N:0] MASK_B = 4'b1101;

  // {xMode[1:0], ones k3, k2, k1, k0}; xMode 0:all 0, 1:all 1, 2:alternating
  localparam logic [17:0] VEC [0:7] = '{
    {2'd1, 4'd4, 4'd4, 4'd4, 4'd4},
    {2'd0, 4'd8, 4'd0, 4'd4, 4'd2},
    {2'd2, 4'd6, 4'd2, 4'd7, 4'd1},
    {2'd1, 4'd8, 4'd8, 4'd8, 4'd8},
    {2'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {2'd2, 4'd0, 4'd8, 4'd0, 4'd8},
    {2'd1, 4'd2, 4'd6, 4'd3, 4'd5},
    {2'd0, 4'd5, 4'd1, 4'd8, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xBit = 1'b0;
  logic [N:0] coefBits = '0;
  logic outA, validA, outB, validB;

  int nChecks = 0;
  int nFail = 0;
  int cnt [0:1][0:N];
  int car [0:1][0:N];
  int accM[0:1][0:N];
  bit rec [0:NB*M-1];

  always #4 clk = ~clk;

  sc_cheb_eval #(.ORDER(N), .BLOCK_LEN(M), .CARRY_W(16)) dut_i (
    .clk(clk), .rst(rst), .xBit(xBit), .coefBits(coefBits),
    .outBit(outA), .outValid(validA));

  sc_cheb_eval #(.ORDER(N), .BLOCK_LEN(M), .CARRY_W(16), .COEF_MASK(MASK_B)) dutMask_i (
    .clk(clk), .rst(rst), .xBit(xBit), .coefBits(coefBits),
    .outBit(outB), .outValid(validB));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4, R8 weights
  function automatic int wC(input int m, input int n);
    return (m == 0) ? 1 : int'(MASK_B[n]);
  endfunction
  function automatic int wP(input int n);
    return (n == N) ? 0 : ((n == 0) ? 1 : 2);
  endfunction
  function automatic int wS(input int n);
    return (n >= N - 1) ? 0 : -1;
  endfunction
  function automatic int baseOf(input int m, input int n);
    return (M * (1 - (wC(m, n) + wP(n) + wS(n)))) / 2;
  endfunction

  task automatic modelInit();
    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= N; n++) begin
        cnt[m][n]  = M / 2;   // R1
        car[m][n]  = 0;
        accM[m][n] = baseOf(m, n);
      end
  endtask

  // One clock of the block-level model (R2, R3, R5, R6)
  task automatic modelCycle(input int p, input bit xb, input logic [N:0] cb);
    for (int m = 0; m < 2; m++) begin
      bit sb [0:N+2];
      for (int n = 0; n <= N; n++) sb[n] = (p < cnt[m][n]);
      sb[N+1] = p[0];
      sb[N+2] = p[0];
      for (int n = 0; n <= N; n++)
        accM[m][n] += wC(m, n) * int'(cb[n]) + wP(n) * int'(xb == sb[n+1])
                      + wS(n) * int'(sb[n+2]);
      if (p == M - 1)
        for (int n = 0; n <= N; n++) begin
          int est, cl;
          est = accM[m][n] + car[m][n];
          cl = (est < 0) ? 0 : ((est > M) ? M : est);
          car[m][n]  = est - cl;
          cnt[m][n]  = cl;
          accM[m][n] = baseOf(m, n);
        end
    end
  endtask

  // mode: 0 plain, 1 record masked output, 2 compare masked output to record
  task automatic runVector(input logic [17:0] v, input int mode);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelInit();
    for (int blk = 0; blk < NB; blk++) begin
      for (int p = 0; p < M; p++) begin
        bit xb;
        logic [N:0] cb;
        xb = (v[17:16] == 2'd0) ? 1'b0 : ((v[17:16] == 2'd1) ? 1'b1 : p[0]);
        for (int n = 0; n <= N; n++) cb[n] = (p < int'(v[4*n +: 4]));
        xBit = xb;
        coefBits = cb;
        check(outA == (p < cnt[0][0]), "R2 R3 R4 R5 R6 full mask", int'(outA), int'(p < cnt[0][0]));
        check(outB == (p < cnt[1][0]), "R2 R4 R6 R8 masked", int'(outB), int'(p < cnt[1][0]));
        check(validA == (blk >= N + 1), "R7 valid timing", int'(validA), int'(blk >= N + 1));
        if (mode == 1) rec[blk*M + p] = outB;
        if (mode == 2) check(outB == rec[blk*M + p], "R8 masked coefficient ignored",
                             int'(outB), int'(rec[blk*M + p]));
        modelCycle(p, xb, cb);
        @(negedge clk);
      end
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state, phase 0 shows the M/2 ones-first pattern
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(validA == 1'b0, "R1 valid low in reset", int'(validA), 0);
    check(outA == 1'b1, "R1 reset count M/2 at phase 0", int'(outA), 1);
    check(validB == 1'b0, "R1 masked valid low in reset", int'(validB), 0);

    for (int i = 0; i < 8; i++) runVector(VEC[i], 0);

    // R8: stage 1 coefficient at opposite extremes, masked instance must not change
    runVector({2'd2, 4'd3, 4'd6, 4'd0, 4'd5}, 1);
    runVector({2'd2, 4'd3, 4'd6, 4'd8, 4'd5}, 2);
    runVector({2'd1, 4'd7, 4'd1, 4'd8, 4'd2}, 1);
    runVector({2'd1, 4'd7, 4'd1, 4'd0, 4'd2}, 2);

    finishRun();
  end

endmodule